// File: doc/BRIEF.md
# Delayed-LMS Weight Update Unit

This block holds the coefficient set of an N-tap adaptive FIR filter and adapts it once per clock with the delayed-LMS rule: every weight moves by the scaled error times the delayed input sample of its own tap. The step size is a negative power of two, so the error is scaled by an arithmetic right shift whose amount is a run-time input. The error itself comes from a separate filtering and error stage. The weight vector on `w_o` drives that filter and also feeds back into the next update.

The scaled error and its multiples (once, twice and three times the scaled error, plus the negated forms needed by the signed top digit) are formed once. They are registered next to the one-cycle latch of the sample vector and shared by every tap. Each tap splits its latched sample into radix-4 digits and picks one shared multiple per digit with AND/OR selection. It sums the partial products by place value and adds the product to its stored weight, with saturation. An enable travels with the sample and the error, so adaptation can be frozen on a chosen sample.

Top module: `dlms_weight_update`

## Requirements
- R1: While `rst_ni` is low, every weight reads zero on `w_o` without waiting for a clock edge, and the weights stay zero until the first update after reset.
- R2: The scaled error equals `err_i` (two's complement) shifted arithmetically right by `mu_shift_i`, that is floor(err / 2^mu_shift). For example -1001 with a shift of 3 gives -126, and 1001 with a shift of 3 gives 125.
- R3: A weight whose exact sum would leave the W-bit signed range is clamped to 2^(W-1)-1 or to -2^(W-1), matching the sign of the overflow.
- R4: A sample presented with `en_i` low changes no weight, whatever its error and sample values are. An update already accepted with `en_i` high still completes.
- R5: For an accepted sample, weight i becomes sat(w_i + scaled_error * x_i). The sum is formed exactly before saturation.
- R6: Inputs sampled at clock edge k show up on `w_o` right after edge k+1 and not earlier, because of one input latch and one weight register.
- R7: Each sample lane is a two's-complement L-bit number over its full range, including -2^(L-1) and 2^(L-1)-1. The most significant radix-4 digit is treated as signed.
- R8: Lane i of `x_i` is bits [i*L +: L] and lane i of `w_o` is bits [i*W +: W]. All lanes in one update use the same scaled error, and each lane uses only its own sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Adapt on this sample when high |
| mu_shift_i | input | $clog2(EW) | Step-size exponent: right-shift amount applied to the error |
| err_i | input | EW | Two's-complement error for this sample |
| x_i | input | N*L | Delayed input samples, one two's-complement lane per tap |
| w_o | output | N*W | Current weights, one two's-complement lane per tap |

## Verification
Saturation and the freeze of adaptation can fall in the same cycle. A saturating update accepted at one edge completes on the next edge, and at that same edge a sample with `en_i` low is latched and must be dropped. The bench provokes this by driving a full-scale error with full-scale samples on one cycle and an opposite full-scale error with `en_i` low on the next. It judges the result by requiring every lane to sit at the positive limit and to stay there. A behavioural model updated every clock also compares all lanes, during directed patterns, random patterns and a closed system-identification loop whose mean squared error must fall by a large factor.

// File: rtl/dlms_pkg.sv
package dlms_pkg;

  // one-hot selection of a radix-4 digit magnitude
  typedef struct packed {
    logic one;
    logic two;
    logic three;
  } digit_sel_t;

  function automatic digit_sel_t decode_digit(input logic [1:0] d);
    digit_sel_t s;
    s.one   = d[0] & ~d[1];
    s.two   = d[1] & ~d[0];
    s.three = d[1] &  d[0];
    return s;
  endfunction

endpackage

// File: rtl/dlms_err_scale.sv
module dlms_err_scale #(
  parameter int EW  = 18,
  parameter int SHW = $clog2(EW),
  localparam int PW = EW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [SHW-1:0]       mu_shift_i,
  input  logic [EW-1:0]        err_i,
  output logic                 en_o,
  output logic signed [PW-1:0] m1_o,
  output logic signed [PW-1:0] m2_o,
  output logic signed [PW-1:0] m3_o,
  output logic signed [PW-1:0] n1_o,
  output logic signed [PW-1:0] n2_o
);

  logic signed [EW-1:0] s_d;
  logic signed [PW-1:0] m1_d, m2_d, m3_d, n1_d, n2_d;

  always_comb begin
    s_d  = $signed(err_i) >>> mu_shift_i;
    m1_d = PW'(s_d);
    m2_d = m1_d <<< 1;
    m3_d = m1_d + m2_d;
    n1_d = -m1_d;
    n2_d = -m2_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= 1'b0;
      m1_o <= '0;
      m2_o <= '0;
      m3_o <= '0;
      n1_o <= '0;
      n2_o <= '0;
    end else begin
      en_o <= en_i;
      m1_o <= m1_d;
      m2_o <= m2_d;
      m3_o <= m3_d;
      n1_o <= n1_d;
      n2_o <= n2_d;
    end
  end

  // floor shift never flips the sign of the error
  assert_sign_pos_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_i[EW-1] |=> !m1_o[PW-1]);
  assert_sign_neg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i[EW-1] |=> m1_o[PW-1]);

endmodule

// File: rtl/dlms_ppg.sv
module dlms_ppg
  import dlms_pkg::*;
#(
  parameter int L  = 8,
  parameter int PW = 20,
  localparam int ND = L / 2
) (
  input  logic [L-1:0]       x_i,
  input  logic [PW-1:0]      m1_i,
  input  logic [PW-1:0]      m2_i,
  input  logic [PW-1:0]      m3_i,
  input  logic [PW-1:0]      n1_i,
  input  logic [PW-1:0]      n2_i,
  output logic [ND*PW-1:0]   pp_o
);

  for (genvar k = 0; k < ND; k++) begin : g_dig
    digit_sel_t sel;
    assign sel = decode_digit(x_i[2*k +: 2]);
    if (k < ND - 1) begin : g_plain
      assign pp_o[k*PW +: PW] = ({PW{sel.one}}   & m1_i)
                              | ({PW{sel.two}}   & m2_i)
                              | ({PW{sel.three}} & m3_i);
    end else begin : g_msd
      // top digit values 0, +1, -2, -1
      assign pp_o[k*PW +: PW] = ({PW{sel.one}}   & m1_i)
                              | ({PW{sel.two}}   & n2_i)
                              | ({PW{sel.three}} & n1_i);
    end
  end

endmodule

// File: rtl/dlms_shift_add.sv
module dlms_shift_add #(
  parameter int ND  = 4,
  parameter int PW  = 20,
  parameter int PRW = 26
) (
  input  logic [ND*PW-1:0]      pp_i,
  output logic signed [PRW-1:0] prod_o
);

  always_comb begin
    logic signed [PRW-1:0] acc;
    acc = '0;
    for (int k = 0; k < ND; k++) begin
      acc = acc + (PRW'($signed(pp_i[k*PW +: PW])) <<< (2 * k));
    end
    prod_o = acc;
  end

endmodule

// File: rtl/dlms_tap.sv
module dlms_tap #(
  parameter int L  = 8,
  parameter int EW = 18,
  parameter int W  = 16,
  localparam int PW  = EW + 2,
  localparam int ND  = L / 2,
  localparam int PRW = EW + L,
  localparam int ACW = ((W > PRW) ? W : PRW) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [L-1:0]        x_i,
  input  logic [PW-1:0]       m1_i,
  input  logic [PW-1:0]       m2_i,
  input  logic [PW-1:0]       m3_i,
  input  logic [PW-1:0]       n1_i,
  input  logic [PW-1:0]       n2_i,
  output logic [W-1:0]        w_o
);

  localparam logic signed [W-1:0] WMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] WMIN = {1'b1, {(W-1){1'b0}}};

  logic [ND*PW-1:0]      pp;
  logic signed [PRW-1:0] prod;
  logic signed [ACW-1:0] sum;
  logic signed [W-1:0]   w_d, w_q;

  dlms_ppg #(.L(L), .PW(PW)) u_ppg (
    .x_i  (x_i),
    .m1_i (m1_i),
    .m2_i (m2_i),
    .m3_i (m3_i),
    .n1_i (n1_i),
    .n2_i (n2_i),
    .pp_o (pp)
  );

  dlms_shift_add #(.ND(ND), .PW(PW), .PRW(PRW)) u_sa (
    .pp_i   (pp),
    .prod_o (prod)
  );

  always_comb begin
    sum = ACW'(w_q) + ACW'(prod);
    if (sum[ACW-1] && !(&sum[ACW-2:W-1]))      w_d = WMIN;
    else if (!sum[ACW-1] && (|sum[ACW-2:W-1])) w_d = WMAX;
    else                                       w_d = sum[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   w_q <= '0;
    else if (en_i) w_q <= w_d;
  end

  assign w_o = w_q;

  logic prod_pos, prod_neg;
  assign prod_pos = !prod[PRW-1] && (|prod);
  assign prod_neg = prod[PRW-1];

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(w_q));
  assert_sat_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && w_q == WMAX && !prod_neg) |=> (w_q == WMAX));
  assert_sat_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && w_q == WMIN && !prod_pos) |=> (w_q == WMIN));
  assert_zero_sample_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_i == '0) |-> (prod == '0));
  assert_grow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && prod_pos && w_q != WMAX) |=> (w_q > $past(w_q)));

endmodule

// File: rtl/dlms_weight_update.sv
module dlms_weight_update #(
  parameter int N   = 4,
  parameter int L   = 8,
  parameter int EW  = 18,
  parameter int W   = 16,
  localparam int SHW = $clog2(EW),
  localparam int PW  = EW + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SHW-1:0]   mu_shift_i,
  input  logic [EW-1:0]    err_i,
  input  logic [N*L-1:0]   x_i,
  output logic [N*W-1:0]   w_o
);

  logic          en_q;
  logic [N*L-1:0] x_q;
  logic [PW-1:0] m1, m2, m3, n1, n2;

  // sample latch ahead of the multipliers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) x_q <= '0;
    else         x_q <= x_i;
  end

  dlms_err_scale #(.EW(EW), .SHW(SHW)) u_scale (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .mu_shift_i (mu_shift_i),
    .err_i      (err_i),
    .en_o       (en_q),
    .m1_o       (m1),
    .m2_o       (m2),
    .m3_o       (m3),
    .n1_o       (n1),
    .n2_o       (n2)
  );

  for (genvar i = 0; i < N; i++) begin : g_tap
    dlms_tap #(.L(L), .EW(EW), .W(W)) u_tap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_q),
      .x_i    (x_q[i*L +: L]),
      .m1_i   (m1),
      .m2_i   (m2),
      .m3_i   (m3),
      .n1_i   (n1),
      .n2_i   (n2),
      .w_o    (w_o[i*W +: W])
    );
  end

  // a zero shared multiple leaves every lane untouched
  assert_zero_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m1 == '0) |=> $stable(w_o));
  // a sample dropped at the input never reaches the weights two edges on
  assert_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i ##1 1'b1) |=> $stable(w_o));

endmodule

// File: tb/sim_dlms_weight_update.sv
module sim_dlms_weight_update;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int L   = 8;
  localparam int EW  = 18;
  localparam int W   = 16;
  localparam int SHW = $clog2(EW);
  localparam longint WMAXV = (64'sd1 <<< (W-1)) - 1;
  localparam longint WMINV = -(64'sd1 <<< (W-1));
  localparam longint EMAXV = (64'sd1 <<< (EW-1)) - 1;
  localparam longint EMINV = -(64'sd1 <<< (EW-1));

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic [SHW-1:0]   mu_shift_i = '0;
  logic [EW-1:0]    err_i = '0;
  logic [N*L-1:0]   x_i = '0;
  logic [N*W-1:0]   w_o;

  dlms_weight_update #(.N(N), .L(L), .EW(EW), .W(W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mu_shift_i(mu_shift_i),
    .err_i(err_i), .x_i(x_i), .w_o(w_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  string cur_req = "R5";

  longint wm[N];
  longint st_e;
  int     st_sh;
  bit     st_en;
  longint st_x[N];
  longint drv_e;
  int     drv_sh;
  bit     drv_en;
  longint drv_x[N];
  longint snap[N];

  function automatic longint sat_w(longint v);
    if (v > WMAXV) return WMAXV;
    if (v < WMINV) return WMINV;
    return v;
  endfunction

  function automatic longint lane_w(int i);
    return longint'($signed(w_o[i*W +: W]));
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin wm[i] = 0; st_x[i] = 0; end
    st_e = 0; st_sh = 0; st_en = 1'b0;
  endtask

  task automatic idle_drv();
    drv_e = 0; drv_sh = 0; drv_en = 1'b0;
    for (int i = 0; i < N; i++) drv_x[i] = 0;
  endtask

  // one clock: drive, edge, update model, compare every lane
  task automatic cycle();
    err_i = drv_e[EW-1:0];
    mu_shift_i = drv_sh[SHW-1:0];
    en_i = drv_en;
    for (int i = 0; i < N; i++) x_i[i*L +: L] = drv_x[i][L-1:0];
    @(posedge clk_i);
    #1;
    if (st_en)
      for (int i = 0; i < N; i++) wm[i] = sat_w(wm[i] + (st_e >>> st_sh) * st_x[i]);
    st_e = drv_e; st_sh = drv_sh; st_en = drv_en;
    for (int i = 0; i < N; i++) st_x[i] = drv_x[i];
    for (int i = 0; i < N; i++) check(lane_w(i) == wm[i], cur_req, lane_w(i), wm[i]);
  endtask

  task automatic check_zero(string req);
    for (int i = 0; i < N; i++) check(lane_w(i) == 0, req, lane_w(i), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R1..: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    longint h[N];
    real mse_a, mse_b;
    longint acc, e;
    h[0] = 12000; h[1] = -9000; h[2] = 5000; h[3] = -2500;
    model_clear();
    idle_drv();
    // R1: reset state
    #2;
    check_zero("R1");
    repeat (3) @(posedge clk_i);
    #1;
    check_zero("R1");
    rst_ni = 1'b1;
    cur_req = "R1";
    cycle();

    // R6: latency of two edges
    cur_req = "R6";
    drv_e = 1000; drv_en = 1'b1;
    drv_x[0] = 1; drv_x[1] = 2; drv_x[2] = -3; drv_x[3] = 4;
    cycle();
    check(lane_w(0) == 0, "R6", lane_w(0), 0);
    idle_drv();
    cycle();
    check(lane_w(0) == 1000, "R6", lane_w(0), 1000);
    check(lane_w(2) == -3000, "R6", lane_w(2), -3000);

    // R2: floor shift of negative and positive errors
    cur_req = "R2";
    drv_e = -1001; drv_sh = 3; drv_en = 1'b1; drv_x[0] = 1;
    cycle();
    idle_drv();
    drv_e = 1001; drv_sh = 3; drv_en = 1'b1; drv_x[1] = 1;
    cycle();
    check(lane_w(0) == 874, "R2", lane_w(0), 874);
    idle_drv();
    cycle();
    check(lane_w(1) == 2125, "R2", lane_w(1), 2125);

    // R7: extreme sample values, signed top digit
    cur_req = "R7";
    drv_e = 37; drv_en = 1'b1;
    drv_x[0] = -128; drv_x[1] = 127; drv_x[2] = -128; drv_x[3] = -1;
    cycle();
    drv_e = -45; drv_sh = 1;
    drv_x[0] = 127; drv_x[1] = -128; drv_x[2] = -2; drv_x[3] = 64;
    cycle();
    idle_drv();
    cycle();

    // R8: lanes independent, error shared
    cur_req = "R8";
    drv_e = -500; drv_sh = 2; drv_en = 1'b1;
    drv_x[0] = 3; drv_x[1] = -5; drv_x[2] = 7; drv_x[3] = -9;
    for (int i = 0; i < N; i++) snap[i] = lane_w(i);
    cycle();
    idle_drv();
    cycle();
    for (int i = 0; i < N; i++)
      check(lane_w(i) - snap[i] == -125 * drv_x[i] + 0 * i + (i == 0 ? -375 : i == 1 ? 625 : i == 2 ? -875 : 1125),
            "R8", lane_w(i) - snap[i], (i == 0 ? -375 : i == 1 ? 625 : i == 2 ? -875 : 1125));

    // R4: disabled samples change nothing
    cur_req = "R4";
    for (int i = 0; i < N; i++) snap[i] = lane_w(i);
    repeat (5) begin
      drv_e = 100000; drv_sh = 0; drv_en = 1'b0;
      for (int i = 0; i < N; i++) drv_x[i] = 127;
      cycle();
    end
    idle_drv();
    cycle();
    for (int i = 0; i < N; i++) check(lane_w(i) == snap[i], "R4", lane_w(i), snap[i]);

    // R3: saturation both ways
    cur_req = "R3";
    drv_e = EMAXV; drv_en = 1'b1;
    for (int i = 0; i < N; i++) drv_x[i] = 127;
    cycle();
    idle_drv();
    cycle();
    for (int i = 0; i < N; i++) check(lane_w(i) == WMAXV, "R3", lane_w(i), WMAXV);
    drv_e = EMINV; drv_en = 1'b1;
    for (int i = 0; i < N; i++) drv_x[i] = 127;
    cycle();
    idle_drv();
    cycle();
    for (int i = 0; i < N; i++) check(lane_w(i) == WMINV, "R3", lane_w(i), WMINV);

    // R4 with R3: saturating update completes while the next sample is frozen
    cur_req = "R4";
    drv_e = EMAXV; drv_en = 1'b1;
    for (int i = 0; i < N; i++) drv_x[i] = 127;
    cycle();
    drv_e = EMINV; drv_en = 1'b0;
    cycle();
    for (int i = 0; i < N; i++) check(lane_w(i) == WMAXV, "R4", lane_w(i), WMAXV);
    idle_drv();
    cycle();
    for (int i = 0; i < N; i++) check(lane_w(i) == WMAXV, "R4", lane_w(i), WMAXV);

    // R5: random patterns
    cur_req = "R5";
    for (int t = 0; t < 300; t++) begin
      drv_e = longint'($urandom_range(0, 262143)) - 131072;
      drv_sh = int'($urandom_range(0, 17));
      drv_en = ($urandom_range(0, 9) < 8);
      for (int i = 0; i < N; i++) drv_x[i] = longint'($urandom_range(0, 255)) - 128;
      cycle();
    end

    // R1 mid-run reset
    idle_drv();
    cycle();
    #1 rst_ni = 1'b0;
    #1;
    check_zero("R1");
    model_clear();
    @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R5: closed identification loop against a fixed reference FIR
    cur_req = "R5";
    mse_a = 0.0; mse_b = 0.0;
    for (int t = 0; t < 2048; t++) begin
      for (int i = 0; i < N; i++) drv_x[i] = longint'($urandom_range(0, 127)) - 64;
      acc = 0;
      for (int i = 0; i < N; i++) acc += (h[i] - wm[i]) * drv_x[i];
      e = acc >>> 6;
      if (e > EMAXV) e = EMAXV;
      if (e < EMINV) e = EMINV;
      if (t < 256) mse_a += real'(e) * real'(e);
      if (t >= 2048 - 256) mse_b += real'(e) * real'(e);
      drv_e = e; drv_sh = 9; drv_en = 1'b1;
      cycle();
    end
    check(mse_b * 64.0 < mse_a, "R5", longint'(mse_b / 256.0), longint'(mse_a / 256.0 / 64.0));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule